// File: doc/BRIEF.md
# Clock Root Configuration Update Controller

This block is the register-facing control logic for one clock root. Software writes the desired source index, pre-divider, fractional mode, hardware-gating enable and the three fractional-divider words into shadow registers. The clock root keeps running on its old settings while these writes happen. A write to the control word with the apply bit set starts a commit. All shadow fields then move into the active set on the same clock edge, and those active fields drive the source multiplexer select and the divider datapaths. The apply bit reads back as one for a fixed number of cycles and then clears without further software action.

A second control bit requests a two-step commit for glitch-sensitive roots. First only the source select moves to a fixed safe source, with its own settle window. Then the complete shadow set is committed in a second window. The control word also reports the root-off status, which it samples from the clock gate.

The sequencer has five states:
- `ST_IDLE`: nothing is pending.
- `ST_SAFE_LOAD`: one cycle that forces the safe source.
- `ST_SAFE_WAIT`: settle time after the safe switch.
- `ST_LOAD`: one cycle that copies the whole shadow set.
- `ST_WAIT`: settle time after the copy.

Its transitions are:
- go-direct: `ST_IDLE` to `ST_LOAD`.
- go-safe: `ST_IDLE` to `ST_SAFE_LOAD`.
- safe-loaded: `ST_SAFE_LOAD` to `ST_SAFE_WAIT`.
- safe-settled: `ST_SAFE_WAIT` to `ST_LOAD`, when the counter expires.
- loaded: `ST_LOAD` to `ST_WAIT`.
- settled: `ST_WAIT` to `ST_IDLE`, when the counter expires.

Top module: `clkroot_ctrl`

## Requirements
- R1: After reset, the active outputs are all zero: source 0, pre-divider 0 (bypass), mode 0 (fractional divider off), hardware gating off, and M/N/D 0. The control word reads 0, meaning no update is pending and the root is running.
- R2: Writes to the configuration word (address 1) and to the M, N and D words (addresses 2, 3, 4) change no active output while no commit is running.
- R3: A write to the control word (address 0) with bit 0 set, when no update is pending, makes control bit 0 read 1 for exactly APPLY_CYCLES cycles, starting in the cycle after the write. The bit then reads 0.
- R4: In a direct commit, every active field takes its shadow value on the same edge, one clock edge after the write edge.
- R5: Shadow writes made while an update is pending are accepted and read back, but the running commit does not apply them. They take effect only with the next commit.
- R6: A control write with bit 0 set while an update is pending is ignored and does not lengthen the pending window.
- R7: A control write with bit 0 clear starts no commit and changes no output.
- R8: A control write with bits 0 and 1 both set moves only the source select to SAFE_SRC one edge after the write. The full shadow set follows APPLY_CYCLES edges later. Control bit 0 reads 1 for 2*APPLY_CYCLES cycles.
- R9: Control bit 31 reads the root-off status input as it was sampled on the previous clock edge.
- R10: The configuration word reads back the shadow fields at fixed positions: pre-divider in bits [DIV_W-1:0], source in bits [8+SEL_W-1:8], mode in bits [13:12] and hardware gating in bit 16. All other bits read 0.
- R11: The M, N and D words keep only their low MND_W bits, both in readback and in the active outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address (0 control, 1 config, 2 M, 3 N, 4 D) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| root_off_i | input | 1 | Root-off status from the clock gate |
| src_sel_o | output | SEL_W | Active source multiplexer select |
| pre_div_o | output | DIV_W | Active pre-divider value |
| mode_o | output | 2 | Active fractional mode |
| hw_ctl_o | output | 1 | Active hardware gating enable |
| m_o | output | MND_W | Active M word |
| n_o | output | MND_W | Active N word |
| d_o | output | MND_W | Active D word |

## Verification
The bench aims at the edges where shadow and active state meet:
- Reconfiguring during a pending commit. A design that copies shadows continuously, rather than once, would show the late write on the outputs early.
- Re-issuing apply while busy. A design that restarts its counter would hold the apply bit longer than APPLY_CYCLES.
- The two-step safe switch. A design that skips it would never show SAFE_SRC; one that also moves the divider fields early would expose a mixed configuration.
- Out-of-field bits and over-wide M/N/D data. A missing mask would show up in readback and in the active outputs.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MW   = 3'd2;
    localparam logic [ADDR_W-1:0] A_NW   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DW   = 3'd4;

    // control word bits
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_SAFE_BIT = 1;
    localparam int CTRL_ROOT_BIT = 31;

    // configuration word field positions
    localparam int CFG_DIV_LSB  = 0;
    localparam int CFG_SEL_LSB  = 8;
    localparam int CFG_MODE_LSB = 12;
    localparam int CFG_MODE_W   = 2;
    localparam int CFG_HW_BIT   = 16;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SAFE_LOAD = 3'd1,
        ST_SAFE_WAIT = 3'd2,
        ST_LOAD      = 3'd3,
        ST_WAIT      = 3'd4
    } seq_state_e;

endpackage

// File: rtl/clkroot_regs.sv
module clkroot_regs
    import clkroot_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int DIV_W = 5,
    parameter int MND_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  root_off_i,
    input  logic                  busy,
    output logic                  go,
    output logic                  via_safe,
    output logic [SEL_W-1:0]      sh_sel,
    output logic [DIV_W-1:0]      sh_div,
    output logic [CFG_MODE_W-1:0] sh_mode,
    output logic                  sh_hw,
    output logic [MND_W-1:0]      sh_m,
    output logic [MND_W-1:0]      sh_n,
    output logic [MND_W-1:0]      sh_d
);

    logic root_q;
    logic wr_ctrl, wr_cfg, wr_m, wr_n, wr_d;
    logic unused_wdata;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
    assign wr_m    = reg_wr && (reg_addr == A_MW);
    assign wr_n    = reg_wr && (reg_addr == A_NW);
    assign wr_d    = reg_wr && (reg_addr == A_DW);

    // a commit request is only taken when nothing is pending
    assign go       = wr_ctrl && reg_wdata[CTRL_GO_BIT] && !busy;
    assign via_safe = reg_wdata[CTRL_SAFE_BIT];

    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_sel  <= '0;
            sh_div  <= '0;
            sh_mode <= '0;
            sh_hw   <= 1'b0;
            sh_m    <= '0;
            sh_n    <= '0;
            sh_d    <= '0;
            root_q  <= 1'b0;
        end else begin
            root_q <= root_off_i;
            if (wr_cfg) begin
                sh_div  <= reg_wdata[CFG_DIV_LSB +: DIV_W];
                sh_sel  <= reg_wdata[CFG_SEL_LSB +: SEL_W];
                sh_mode <= reg_wdata[CFG_MODE_LSB +: CFG_MODE_W];
                sh_hw   <= reg_wdata[CFG_HW_BIT];
            end
            if (wr_m) sh_m <= reg_wdata[MND_W-1:0];
            if (wr_n) sh_n <= reg_wdata[MND_W-1:0];
            if (wr_d) sh_d <= reg_wdata[MND_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_GO_BIT]   = busy;
                reg_rdata[CTRL_ROOT_BIT] = root_q;
            end
            A_CFG: begin
                reg_rdata[CFG_DIV_LSB +: DIV_W]       = sh_div;
                reg_rdata[CFG_SEL_LSB +: SEL_W]       = sh_sel;
                reg_rdata[CFG_MODE_LSB +: CFG_MODE_W] = sh_mode;
                reg_rdata[CFG_HW_BIT]                 = sh_hw;
            end
            A_MW:    reg_rdata[MND_W-1:0] = sh_m;
            A_NW:    reg_rdata[MND_W-1:0] = sh_n;
            A_DW:    reg_rdata[MND_W-1:0] = sh_d;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/clkroot_seq.sv
module clkroot_seq
    import clkroot_pkg::*;
#(
    parameter int APPLY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       via_safe,
    output logic       busy,
    output logic       load_safe,
    output logic       load_all,
    output seq_state_e state_o
);

    localparam int CNT_W = $clog2(APPLY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(APPLY_CYCLES - 2);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state and settle counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = via_safe ? ST_SAFE_LOAD : ST_LOAD;
            end
            ST_SAFE_LOAD: begin
                state_d = ST_SAFE_WAIT;
                cnt_d   = '0;
            end
            ST_SAFE_WAIT: begin
                if (cnt_q == CNT_LAST) state_d = ST_LOAD;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            ST_LOAD: begin
                state_d = ST_WAIT;
                cnt_d   = '0;
            end
            ST_WAIT: begin
                if (cnt_q == CNT_LAST) state_d = ST_IDLE;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        load_safe = 1'b0;
        load_all  = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy      = 1'b0;
            ST_SAFE_LOAD: load_safe = 1'b1;
            ST_SAFE_WAIT: busy      = 1'b1;
            ST_LOAD:      load_all  = 1'b1;
            ST_WAIT:      busy      = 1'b1;
            default:      busy      = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/clkroot_active.sv
module clkroot_active
    import clkroot_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int DIV_W    = 5,
    parameter int MND_W    = 8,
    parameter int SAFE_SRC = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_safe,
    input  logic                  load_all,
    input  logic [SEL_W-1:0]      sh_sel,
    input  logic [DIV_W-1:0]      sh_div,
    input  logic [CFG_MODE_W-1:0] sh_mode,
    input  logic                  sh_hw,
    input  logic [MND_W-1:0]      sh_m,
    input  logic [MND_W-1:0]      sh_n,
    input  logic [MND_W-1:0]      sh_d,
    output logic [SEL_W-1:0]      act_sel,
    output logic [DIV_W-1:0]      act_div,
    output logic [CFG_MODE_W-1:0] act_mode,
    output logic                  act_hw,
    output logic [MND_W-1:0]      act_m,
    output logic [MND_W-1:0]      act_n,
    output logic [MND_W-1:0]      act_d
);

    localparam logic [SEL_W-1:0] SAFE_IDX = SEL_W'(SAFE_SRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel  <= '0;
            act_div  <= '0;
            act_mode <= '0;
            act_hw   <= 1'b0;
            act_m    <= '0;
            act_n    <= '0;
            act_d    <= '0;
        end else if (load_all) begin
            act_sel  <= sh_sel;
            act_div  <= sh_div;
            act_mode <= sh_mode;
            act_hw   <= sh_hw;
            act_m    <= sh_m;
            act_n    <= sh_n;
            act_d    <= sh_d;
        end else if (load_safe) begin
            act_sel  <= SAFE_IDX;
        end
    end

endmodule

// File: rtl/clkroot_ctrl.sv
module clkroot_ctrl
    import clkroot_pkg::*;
#(
    parameter int SEL_W        = 3,
    parameter int DIV_W        = 5,
    parameter int MND_W        = 8,
    parameter int APPLY_CYCLES = 4,
    parameter int SAFE_SRC     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              root_off_i,
    output logic [SEL_W-1:0]  src_sel_o,
    output logic [DIV_W-1:0]  pre_div_o,
    output logic [1:0]        mode_o,
    output logic              hw_ctl_o,
    output logic [MND_W-1:0]  m_o,
    output logic [MND_W-1:0]  n_o,
    output logic [MND_W-1:0]  d_o
);

    logic                  busy, go, via_safe, load_safe, load_all;
    seq_state_e            seq_state;
    logic [SEL_W-1:0]      sh_sel;
    logic [DIV_W-1:0]      sh_div;
    logic [CFG_MODE_W-1:0] sh_mode;
    logic                  sh_hw;
    logic [MND_W-1:0]      sh_m, sh_n, sh_d;

    clkroot_regs #(
        .SEL_W(SEL_W), .DIV_W(DIV_W), .MND_W(MND_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .root_off_i(root_off_i), .busy(busy),
        .go(go), .via_safe(via_safe),
        .sh_sel(sh_sel), .sh_div(sh_div), .sh_mode(sh_mode), .sh_hw(sh_hw),
        .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d)
    );

    clkroot_seq #(
        .APPLY_CYCLES(APPLY_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .via_safe(via_safe),
        .busy(busy), .load_safe(load_safe), .load_all(load_all),
        .state_o(seq_state)
    );

    clkroot_active #(
        .SEL_W(SEL_W), .DIV_W(DIV_W), .MND_W(MND_W), .SAFE_SRC(SAFE_SRC)
    ) u_act (
        .clk(clk), .rst_n(rst_n),
        .load_safe(load_safe), .load_all(load_all),
        .sh_sel(sh_sel), .sh_div(sh_div), .sh_mode(sh_mode), .sh_hw(sh_hw),
        .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d),
        .act_sel(src_sel_o), .act_div(pre_div_o), .act_mode(mode_o),
        .act_hw(hw_ctl_o), .act_m(m_o), .act_n(n_o), .act_d(d_o)
    );

endmodule

// File: rtl/clkroot_ctrl_chk.sv
module clkroot_ctrl_chk
    import clkroot_pkg::*;
#(
    parameter int SEL_W        = 3,
    parameter int DIV_W        = 5,
    parameter int MND_W        = 8,
    parameter int APPLY_CYCLES = 4,
    parameter int SAFE_SRC     = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             root_off_i,
    input logic [SEL_W-1:0] src_sel_o,
    input logic [DIV_W-1:0] pre_div_o,
    input logic [MND_W-1:0] m_o,
    input logic             busy,
    input seq_state_e       seq_state
);

    localparam int RUN_MAX = 2 * APPLY_CYCLES;

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable({src_sel_o, pre_div_o, m_o}));

    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_GO_BIT]));

    p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RUN_MAX));

    p_safe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_SAFE_WAIT) |-> (src_sel_o == SEL_W'(SAFE_SRC)));

    p_root_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_addr == A_CTRL) |-> (reg_rdata[CTRL_ROOT_BIT] == $past(root_off_i)));

endmodule

bind clkroot_ctrl clkroot_ctrl_chk #(
    .SEL_W(SEL_W), .DIV_W(DIV_W), .MND_W(MND_W),
    .APPLY_CYCLES(APPLY_CYCLES), .SAFE_SRC(SAFE_SRC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .root_off_i(root_off_i),
    .src_sel_o(src_sel_o), .pre_div_o(pre_div_o), .m_o(m_o),
    .busy(busy), .seq_state(seq_state)
);

// File: tb/tb_clkroot_ctrl.sv
`timescale 1ns/1ps
module tb_clkroot_ctrl;

    localparam int APPLY = 4;
    localparam int SAFE  = 1;
    localparam int NV    = 4;

    localparam logic [31:0] V_CFG [NV] = '{32'h0000_1203, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_2511};
    localparam logic [31:0] V_M   [NV] = '{32'h0000_0105, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0033};
    localparam logic [31:0] V_N   [NV] = '{32'hFFFF_FF80, 32'h0000_0001, 32'h0000_007F, 32'h0000_00CC};
    localparam logic [31:0] V_D   [NV] = '{32'h0000_0012, 32'h0000_ABCD, 32'h0000_0040, 32'h003C_000F};
    localparam logic [2:0]  E_SEL [NV] = '{3'd2, 3'd7, 3'd0, 3'd5};
    localparam logic [4:0]  E_DIV [NV] = '{5'h03, 5'h1F, 5'h00, 5'h11};
    localparam logic [1:0]  E_MOD [NV] = '{2'd1, 2'd3, 2'd0, 2'd2};
    localparam logic        E_HW  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [7:0]  E_M   [NV] = '{8'h05, 8'hFF, 8'h00, 8'h33};
    localparam logic [7:0]  E_N   [NV] = '{8'h80, 8'h01, 8'h7F, 8'hCC};
    localparam logic [7:0]  E_D   [NV] = '{8'h12, 8'hCD, 8'h40, 8'h0F};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        root_off_i = 1'b0;
    logic [2:0]  src_sel_o;
    logic [4:0]  pre_div_o;
    logic [1:0]  mode_o;
    logic        hw_ctl_o;
    logic [7:0]  m_o, n_o, d_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    clkroot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .root_off_i(root_off_i),
        .src_sel_o(src_sel_o), .pre_div_o(pre_div_o), .mode_o(mode_o),
        .hw_ctl_o(hw_ctl_o), .m_o(m_o), .n_o(n_o), .d_o(d_o)
    );

    function automatic logic [63:0] pk(logic [2:0] s, logic [4:0] dv, logic [1:0] md,
                                       logic h, logic [7:0] m, logic [7:0] n, logic [7:0] d);
        return {29'd0, s, dv, md, h, m, n, d};
    endfunction

    function automatic logic [31:0] cfg_word(logic [2:0] s, logic [4:0] dv, logic [1:0] md, logic h);
        return (32'(h) << 16) | (32'(md) << 12) | (32'(s) << 8) | 32'(dv);
    endfunction

    function automatic logic [63:0] act();
        return pk(src_sel_o, pre_div_o, mode_o, hw_ctl_o, m_o, n_o, d_o);
    endfunction

    task automatic check(input string req, input logic [63:0] a, input logic [63:0] e);
        tests++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    // caller stands at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [63:0] cur, nxt, a_set, b_set;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", act(), 64'd0);
        rd(3'd0, r);
        check("R1 ctrl", 64'(r), 64'd0);
        cur = 64'd0;

        // table walk: R2 R3 R4 R10 R11
        for (int v = 0; v < NV; v++) begin
            nxt = pk(E_SEL[v], E_DIV[v], E_MOD[v], E_HW[v], E_M[v], E_N[v], E_D[v]);
            wr(3'd1, V_CFG[v]);
            wr(3'd2, V_M[v]);
            wr(3'd3, V_N[v]);
            wr(3'd4, V_D[v]);
            check("R2 shadow only", act(), cur);
            rd(3'd1, r);
            check("R10 cfg readback", 64'(r), 64'(cfg_word(E_SEL[v], E_DIV[v], E_MOD[v], E_HW[v])));
            rd(3'd2, r);
            check("R11 m readback", 64'(r), 64'(E_M[v]));
            rd(3'd4, r);
            check("R11 d readback", 64'(r), 64'(E_D[v]));
            wr(3'd0, 32'h1);
            for (int j = 0; j < APPLY; j++) begin
                rd(3'd0, r);
                check("R3 busy", 64'(r[0]), 64'd1);
                if (j == 0) check("R4 not yet", act(), cur);
                if (j == 1) check("R4 all fields", act(), nxt);
                @(negedge clk);
            end
            rd(3'd0, r);
            check("R3 cleared", 64'(r[0]), 64'd0);
            cur = nxt;
        end

        // R9 root-off status
        root_off_i = 1'b1;
        @(negedge clk);
        rd(3'd0, r);
        check("R9 root off", 64'(r[31]), 64'd1);
        root_off_i = 1'b0;
        @(negedge clk);
        rd(3'd0, r);
        check("R9 root on", 64'(r[31]), 64'd0);

        // R7 control write without apply bit
        a_set = pk(3'd6, 5'h0A, 2'd1, 1'b0, E_M[3], E_N[3], E_D[3]);
        wr(3'd1, cfg_word(3'd6, 5'h0A, 2'd1, 1'b0));
        wr(3'd0, 32'h0000_0002);
        @(negedge clk);
        rd(3'd0, r);
        check("R7 no busy", 64'(r[0]), 64'd0);
        check("R7 no change", act(), cur);

        // R5 / R6 writes and re-apply while pending
        b_set = pk(3'd3, 5'h04, 2'd2, 1'b1, E_M[3], E_N[3], E_D[3]);
        wr(3'd0, 32'h1);
        @(negedge clk);
        wr(3'd1, cfg_word(3'd3, 5'h04, 2'd2, 1'b1));
        wr(3'd0, 32'h1);
        rd(3'd0, r);
        check("R6 still busy", 64'(r[0]), 64'd1);
        @(negedge clk);
        rd(3'd0, r);
        check("R6 not extended", 64'(r[0]), 64'd0);
        check("R5 old set applied", act(), a_set);
        rd(3'd1, r);
        check("R5 late write kept", 64'(r), 64'(cfg_word(3'd3, 5'h04, 2'd2, 1'b1)));
        wr(3'd0, 32'h1);
        @(negedge clk);
        check("R5 next commit", act(), b_set);
        repeat (APPLY) @(negedge clk);
        cur = b_set;

        // R8 two-step safe commit
        nxt = pk(3'd6, 5'h1E, 2'd3, 1'b0, E_M[3], E_N[3], E_D[3]);
        wr(3'd1, cfg_word(3'd6, 5'h1E, 2'd3, 1'b0));
        wr(3'd0, 32'h3);
        check("R8 not yet", act(), cur);
        @(negedge clk);
        check("R8 safe only", act(), {cur[63:35], 3'(SAFE), cur[31:0]});
        repeat (3) @(negedge clk);
        check("R8 safe held", act(), {cur[63:35], 3'(SAFE), cur[31:0]});
        rd(3'd0, r);
        check("R8 busy mid", 64'(r[0]), 64'd1);
        @(negedge clk);
        check("R8 full set", act(), nxt);
        repeat (2) @(negedge clk);
        rd(3'd0, r);
        check("R8 busy end", 64'(r[0]), 64'd1);
        @(negedge clk);
        rd(3'd0, r);
        check("R8 cleared", 64'(r[0]), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule